// File: doc/BRIEF.md
# Line-Granular Store Backup Buffer

This block keeps an ordered record of stores that allocate a cache line, so that each one can later be either written back to memory or thrown away. A store arrives on the record port with its address, a data word and a cacheable indication. Only cacheable stores enter the buffer. New entries go after the existing ones, so the buffer always holds stores in the order they arrived.

A line invalidate gives an address. The block compares that address with every held entry at 32-byte line granularity and picks the oldest entry on the same line. The entry is taken out of the buffer in that cycle, and the later entries move up by one place. The entry's own address and data then appear on a valid/ready memory write port until memory accepts them. While that write is outstanding, further invalidates are held off. A discard input drops every entry at once and writes nothing.

Top module: `line_store_backup`

## Requirements
- R1: A record with `rec_valid_i` and `rec_cacheable_i` high adds one entry, so `count_o` goes up by one after the edge. A record with `rec_cacheable_i` low leaves `count_o` and the contents unchanged.
- R2: Entries are kept in arrival order. When several entries share a line, repeated invalidates of that line replay them oldest first.
- R3: An invalidate matches an entry when the address bits above bit 4 are equal in both addresses. Bits 4:0 are ignored, which gives a 32-byte line.
- R4: An invalidate removes only the oldest matching entry. Later entries on the same line stay in the buffer, and `count_o` drops by exactly one.
- R5: The replayed write carries the stored entry's full address and 32-bit data, not the invalidate address.
- R6: `discard_i` empties the buffer (`count_o` = 0) and issues no memory write. It wins over a record or an invalidate in the same cycle.
- R7: `full_o` is high when `count_o` equals DEPTH (default 8). A cacheable record made while full is dropped and sets `overflow_o`, which stays set until reset.
- R8: An accepted invalidate that matches raises `mem_valid_o` in the next cycle. Address and data hold steady until `mem_ready_i` is seen, and `inv_ready_o` stays low for that whole time.
- R9: An invalidate that matches nothing completes in its own cycle. It issues no write, leaves `count_o` unchanged and keeps `inv_ready_o` high.
- R10: Removing an entry from the middle keeps the relative order of the entries before it and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rec_valid_i | input | 1 | Record request |
| rec_addr_i | input | 32 | Store address |
| rec_data_i | input | 32 | Store data |
| rec_cacheable_i | input | 1 | Store targets a cacheable region |
| inv_valid_i | input | 1 | Line invalidate request |
| inv_addr_i | input | 32 | Invalidate address |
| inv_ready_o | output | 1 | Invalidate can be accepted |
| discard_i | input | 1 | Drop all entries |
| mem_valid_o | output | 1 | Replay write valid |
| mem_addr_o | output | 32 | Replay write address |
| mem_data_o | output | 32 | Replay write data |
| mem_ready_i | input | 1 | Memory accepts the write |
| full_o | output | 1 | Buffer holds DEPTH entries |
| overflow_o | output | 1 | Sticky: a cacheable record was dropped |
| count_o | output | 4 | Number of held entries |

## Verification
Records, discards and invalidate removals change `count_o` one edge after the request. A matching invalidate raises `mem_valid_o` one edge after acceptance, and `inv_ready_o` falls at the same time. After the edge where `mem_ready_i` is seen, `mem_valid_o` is low and `inv_ready_o` is high again. The bench drives every input on the falling edge, holds it across exactly one rising edge, and reads the outputs on the next falling edge. It checks that the write fields stay steady during every cycle that ready is held low.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int unsigned LSB_ADDR_W = 32;
  localparam int unsigned LSB_DATA_W = 32;

  typedef struct packed {
    logic [LSB_ADDR_W-1:0] addr;
    logic [LSB_DATA_W-1:0] data;
  } lsb_entry_t;
endpackage

// File: rtl/lsb_line_find.sv
module lsb_line_find
  import lsb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned OFS_W = 5,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  lsb_entry_t             entries_i [DEPTH],
  input  logic [CNT_W-1:0]       count_i,
  input  logic [LSB_ADDR_W-1:0]  key_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       hit_idx_o
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = (g < count_i) &&
      (entries_i[g].addr[LSB_ADDR_W-1:OFS_W] == key_i[LSB_ADDR_W-1:OFS_W]);
  end

  // oldest (lowest index) match wins
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lsb_store.sv
module lsb_store
  import lsb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             remove_i,
  input  logic [IDX_W-1:0] remove_idx_i,
  input  logic             append_i,
  input  lsb_entry_t       append_entry_i,
  output lsb_entry_t       entries_o [DEPTH],
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q, count_mid;

  assign count_mid = count_q - CNT_W'(remove_i);
  assign count_o   = count_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    lsb_entry_t slot_q;
    logic       shift_in;
    if (g < DEPTH - 1) begin : g_shift
      assign shift_in = remove_i && (IDX_W'(g) >= remove_idx_i);
    end else begin : g_last
      assign shift_in = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (!clear_i) begin
        if (append_i && (count_mid == CNT_W'(g))) slot_q <= append_entry_i;
        else if (shift_in)                        slot_q <= entries_o[(g + 1) % DEPTH];
      end
    end
    assign entries_o[g] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (clear_i)  count_q <= '0;
    else               count_q <= count_mid + CNT_W'(append_i);
  end

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_q == '0);
  assert_remove_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remove_i && !append_i && !clear_i) |=> count_q == $past(count_q) - 1'b1);
endmodule

// File: rtl/line_store_backup.sv
module line_store_backup
  import lsb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned OFS_W = 5,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rec_valid_i,
  input  logic [LSB_ADDR_W-1:0] rec_addr_i,
  input  logic [LSB_DATA_W-1:0] rec_data_i,
  input  logic                  rec_cacheable_i,
  input  logic                  inv_valid_i,
  input  logic [LSB_ADDR_W-1:0] inv_addr_i,
  output logic                  inv_ready_o,
  input  logic                  discard_i,
  output logic                  mem_valid_o,
  output logic [LSB_ADDR_W-1:0] mem_addr_o,
  output logic [LSB_DATA_W-1:0] mem_data_o,
  input  logic                  mem_ready_i,
  output logic                  full_o,
  output logic                  overflow_o,
  output logic [CNT_W-1:0]      count_o
);
  lsb_entry_t       entries [DEPTH];
  lsb_entry_t       new_entry, pend_q;
  logic             hit, inv_fire, remove, append, rec_try, pend_valid_q, ovf_q;
  logic [IDX_W-1:0] hit_idx;

  assign rec_try   = rec_valid_i && rec_cacheable_i && !discard_i;
  assign append    = rec_try && !full_o;
  assign inv_fire  = inv_valid_i && inv_ready_o && !discard_i;
  assign remove    = inv_fire && hit;
  assign new_entry = '{addr: rec_addr_i, data: rec_data_i};
  assign full_o    = (count_o == CNT_W'(DEPTH));

  lsb_line_find #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_find (
    .entries_i (entries),
    .count_i   (count_o),
    .key_i     (inv_addr_i),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  lsb_store #(.DEPTH(DEPTH)) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (discard_i),
    .remove_i       (remove),
    .remove_idx_i   (hit_idx),
    .append_i       (append),
    .append_entry_i (new_entry),
    .entries_o      (entries),
    .count_o        (count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_q <= 1'b0;
      pend_q       <= '0;
    end else if (remove) begin
      pend_valid_q <= 1'b1;
      pend_q       <= entries[hit_idx];
    end else if (mem_ready_i) begin
      pend_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_q <= 1'b0;
    else if (rec_try && full_o) ovf_q <= 1'b1;
  end

  assign inv_ready_o = !pend_valid_q;
  assign mem_valid_o = pend_valid_q;
  assign mem_addr_o  = pend_q.addr;
  assign mem_data_o  = pend_q.data;
  assign overflow_o  = ovf_q;

  assert_write_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));
  assert_backpressure_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !inv_ready_o);
  assert_overflow_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  assert_full_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && rec_try && !inv_fire) |=> (overflow_o && full_o));
  assert_noncache_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && !rec_cacheable_i && !inv_fire && !discard_i) |=> $stable(count_o));
  assert_discard_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_i && !mem_valid_o) |=> !mem_valid_o);
endmodule

// File: tb/line_store_backup_tb_top.sv
module line_store_backup_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rec_valid = 0, rec_cache = 0, inv_valid = 0, discard = 0, mem_ready = 0;
  logic [31:0] rec_addr = 0, rec_data = 0, inv_addr = 0;
  logic        inv_ready, mem_valid, full, overflow;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  count;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  line_store_backup dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rec_valid_i(rec_valid), .rec_addr_i(rec_addr), .rec_data_i(rec_data),
    .rec_cacheable_i(rec_cache),
    .inv_valid_i(inv_valid), .inv_addr_i(inv_addr), .inv_ready_o(inv_ready),
    .discard_i(discard),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_ready_i(mem_ready),
    .full_o(full), .overflow_o(overflow), .count_o(count)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic record(logic [31:0] a, logic [31:0] d, logic c);
    rec_valid = 1; rec_addr = a; rec_data = d; rec_cache = c;
    @(negedge clk);
    rec_valid = 0; rec_cache = 0;
  endtask

  task automatic invalidate(logic [31:0] a);
    inv_valid = 1; inv_addr = a;
    @(negedge clk);
    inv_valid = 0;
  endtask

  // one write due now; hold ready low for stall cycles
  task automatic expect_write(string req, logic [31:0] a, logic [31:0] d, int stall);
    chk({req, " valid"}, 32'(mem_valid), 1);
    chk({req, " addr"}, mem_addr, a);
    chk({req, " data"}, mem_data, d);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R8 hold valid", 32'(mem_valid), 1);
      chk("R8 hold addr", mem_addr, a);
      chk("R8 inv_ready low", 32'(inv_ready), 0);
    end
    mem_ready = 1;
    @(negedge clk);
    mem_ready = 0;
    chk("R8 write retired", 32'(mem_valid), 0);
    chk("R8 inv_ready back", 32'(inv_ready), 1);
  endtask

  task automatic t_reset();
    chk("reset count", 32'(count), 0);
    chk("reset full", 32'(full), 0);
    chk("reset overflow", 32'(overflow), 0);
    chk("reset mem_valid", 32'(mem_valid), 0);
    chk("reset inv_ready", 32'(inv_ready), 1);
  endtask

  task automatic t_record_and_replay();
    record(32'h1000_0004, 32'h11, 1); chk("R1 count", 32'(count), 1);
    record(32'h2000_0000, 32'h99, 0); chk("R1 noncacheable", 32'(count), 1);
    record(32'h1000_0018, 32'h22, 1);
    record(32'h2000_0040, 32'h33, 1);
    record(32'h1000_0010, 32'h44, 1); chk("R1 count 4", 32'(count), 4);
    invalidate(32'h1000_001C);
    chk("R4 count", 32'(count), 3);
    expect_write("R5 R3 first match", 32'h1000_0004, 32'h11, 3);
    invalidate(32'h3000_0000);
    chk("R9 no write", 32'(mem_valid), 0);
    chk("R9 count", 32'(count), 3);
    chk("R9 ready", 32'(inv_ready), 1);
    invalidate(32'h2000_005F);
    chk("R10 count", 32'(count), 2);
    expect_write("R10 middle", 32'h2000_0040, 32'h33, 0);
    invalidate(32'h1000_0000);
    expect_write("R2 order a", 32'h1000_0018, 32'h22, 1);
    invalidate(32'h1000_0000);
    expect_write("R2 order b", 32'h1000_0010, 32'h44, 0);
    chk("R4 empty", 32'(count), 0);
  endtask

  task automatic t_discard();
    record(32'h4000_0000, 32'h1, 1);
    record(32'h4000_0020, 32'h2, 1);
    discard = 1; rec_valid = 1; rec_cache = 1; rec_addr = 32'h4000_0040;
    inv_valid = 1; inv_addr = 32'h4000_0000;
    @(negedge clk);
    discard = 0; rec_valid = 0; inv_valid = 0;
    chk("R6 emptied", 32'(count), 0);
    chk("R6 no write", 32'(mem_valid), 0);
    invalidate(32'h4000_0040);
    chk("R6 record lost", 32'(mem_valid), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) record(32'h5000_0000 + 32'(i) * 32'h40, 32'(i) + 32'h70, 1);
    chk("R7 full", 32'(full), 1);
    chk("R7 no overflow yet", 32'(overflow), 0);
    record(32'h6000_0000, 32'hDEAD, 1);
    chk("R7 overflow", 32'(overflow), 1);
    chk("R7 count held", 32'(count), 8);
    invalidate(32'h6000_0000);
    chk("R7 dropped absent", 32'(mem_valid), 0);
    invalidate(32'h5000_0000);
    expect_write("R7 head kept", 32'h5000_0000, 32'h70, 0);
    chk("R7 not full", 32'(full), 0);
    chk("R7 overflow sticky", 32'(overflow), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_record_and_replay();
        t_discard();
        t_full();
        done = 1;
      end
      begin
        repeat (5000) @(negedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule